// File: doc/BRIEF.md
# Pipeline Register with Serial Shadow Scan

This block is a parallel pipeline register that sits in a data or control path. Next to it is a shadow register of the same width. The shadow register lets a test controller or a boot loader reach the pipeline contents over a serial line. The pipeline register takes a word from the data input on its own clock and presents it on the Y side. The shadow register runs on a separate diagnostic clock. It can shift serially, capture the word present on the Y lines, or hold its word and present it back onto the data-input lines. The last operation lets a word that has been scanned in be written into an external control-store memory.

Several copies can be chained, each serial output feeding the next serial input, to form one long scan loop through a system. In mode 1 the serial input steers the shadow register and no longer acts as data. In this mode the serial output passes the serial input straight through, so a stage that is not shifting drops out of the loop. The bidirectional D and Y lines are modelled as separate value and enable pins. Whatever sits outside the block resolves them. The data and control pins are plain level signals and carry no handshake, because every transfer is tied to a clock edge chosen by the controller.

Top module: `scan_pipe_reg`

## Requirements
- R1: While `rst_n` is low, the shadow register, the pipeline register and the D-drive enable `d_oe` are all zero.
- R2: On a rising `pclk` edge with `mode` = 0, the pipeline register loads `d_in`.
- R3: On a rising `dclk` edge with `mode` = 0, the shadow register shifts toward its MSB: bit i takes bit i-1 and bit 0 takes `sdi`. In mode 0, `sdo` shows shadow bit W-1.
- R4: On a rising `pclk` edge with `mode` = 1, the pipeline register loads the shadow register contents.
- R5: On a rising `dclk` edge with `mode` = 1 and `sdi` = 0, the shadow register loads `y_in`, the resolved level of the Y lines.
- R6: On a rising `dclk` edge with `mode` = 1 and `sdi` = 1, the shadow register keeps its value and `d_oe` goes to 1. Any other `dclk` edge clears `d_oe`. `d_out` always carries the shadow contents.
- R7: With `mode` = 1, `sdo` equals `sdi` combinationally.
- R8: `y_out` carries the pipeline contents. `y_oe` is 1 exactly when `oey_n` is 0.
- R9: With `mode` = 1 and `sdi` = 0, coincident rising edges of `dclk` and `pclk` exchange the shadow and pipeline contents.
- R10: The two clocks are independent. A `pclk` load from `d_in` and a `dclk` shift on the same instant both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both registers |
| dclk | input | 1 | Shadow (diagnostic) register clock |
| pclk | input | 1 | Pipeline register clock |
| mode | input | 1 | 0: normal path and serial shift; 1: diagnostic transfers |
| sdi | input | 1 | Serial data in; in mode 1 selects capture (0) or present (1) |
| sdo | output | 1 | Serial data out: shadow MSB in mode 0, `sdi` in mode 1 |
| d_in | input | W | Resolved level of the D lines |
| d_out | output | W | Value offered to the D lines (shadow contents) |
| d_oe | output | 1 | Drive enable for the D lines |
| y_in | input | W | Resolved level of the Y lines |
| y_out | output | W | Value offered to the Y lines (pipeline contents) |
| y_oe | output | 1 | Drive enable for the Y lines |
| oey_n | input | 1 | Active-low Y output enable |

## Verification
The hardest case to reach is the exchange of contents on coincident clock edges. It needs known, distinct words in both registers at once. Both words can only be placed there through the serial path and the D port. The stimulus scans a 16-bit word through two chained copies and moves it into the pipeline registers. It sends it back through the Y lines into the shadow registers, then loads a second word from D. It then fires both clocks together and scans the result out, comparing bit by bit against a reference model. A capture made with the Y lines released checks that the shadow register takes the resolved line level.

// File: rtl/scan_pipe_pkg.sv
package scan_pipe_pkg;

  // Operation performed by the shadow register on a diagnostic clock edge.
  typedef enum logic [1:0] {
    SH_SHIFT   = 2'd0,
    SH_CAPTURE = 2'd1,
    SH_PRESENT = 2'd2
  } shadow_op_e;

  // Mode and serial input together choose the shadow operation.
  function automatic shadow_op_e decode_shadow_op(input logic mode, input logic ser);
    if (!mode)     return SH_SHIFT;
    else if (!ser) return SH_CAPTURE;
    else           return SH_PRESENT;
  endfunction

endpackage

// File: rtl/spr_shadow_reg.sv
module spr_shadow_reg
  import scan_pipe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  shadow_op_e   op,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q,
  output logic         drive_en
);

  logic [W-1:0] nxt;

  // Per-bit next-state selection.
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic shift_src;
      if (i == 0) begin : g_lsb
        assign shift_src = ser_in;
      end else begin : g_upper
        assign shift_src = q[i-1];
      end
      always_comb begin
        unique case (op)
          SH_SHIFT:   nxt[i] = shift_src;
          SH_CAPTURE: nxt[i] = par_in[i];
          default:    nxt[i] = q[i];
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= '0;
      drive_en <= 1'b0;
    end else begin
      q        <= nxt;
      drive_en <= (op == SH_PRESENT);
    end
  end

endmodule

// File: rtl/spr_pipe_reg.sv
module spr_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         from_shadow,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] shadow_in,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           q <= '0;
    else if (from_shadow) q <= shadow_in;
    else                  q <= data_in;
  end

endmodule

// File: rtl/scan_pipe_reg.sv
module scan_pipe_reg
  import scan_pipe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         dclk,
  input  logic         pclk,
  input  logic         mode,
  input  logic         sdi,
  output logic         sdo,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out,
  output logic         d_oe,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] y_out,
  output logic         y_oe,
  input  logic         oey_n
);

  localparam int MSB = W - 1;

  shadow_op_e   sh_op;
  logic [W-1:0] shadow_q;
  logic [W-1:0] pipe_q;
  logic         sh_drive;

  assign sh_op = decode_shadow_op(mode, sdi);

  spr_shadow_reg #(.W(W)) u_shadow (
    .clk      (dclk),
    .rst_n    (rst_n),
    .op       (sh_op),
    .ser_in   (sdi),
    .par_in   (y_in),
    .q        (shadow_q),
    .drive_en (sh_drive)
  );

  spr_pipe_reg #(.W(W)) u_pipe (
    .clk         (pclk),
    .rst_n       (rst_n),
    .from_shadow (mode),
    .data_in     (d_in),
    .shadow_in   (shadow_q),
    .q           (pipe_q)
  );

  // In mode 1 the serial path bypasses this stage.
  assign sdo   = mode ? sdi : shadow_q[MSB];
  assign d_out = shadow_q;
  assign d_oe  = sh_drive;
  assign y_out = pipe_q;
  assign y_oe  = ~oey_n;

endmodule

// File: rtl/scan_pipe_reg_chk.sv
module scan_pipe_reg_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         dclk,
  input logic         pclk,
  input logic         mode,
  input logic         sdi,
  input logic [W-1:0] d_in,
  input logic [W-1:0] y_in,
  input logic [W-1:0] y_out,
  input logic         d_oe,
  input logic [W-1:0] shadow_q
);

  assert_normal_load_R2: assert property (@(posedge pclk) disable iff (!rst_n)
    !mode |=> y_out == $past(d_in));

  assert_shadow_to_pipe_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    mode |=> y_out == $past(shadow_q));

  assert_shift_lsb_R3: assert property (@(posedge dclk) disable iff (!rst_n)
    !mode |=> shadow_q[0] == $past(sdi));

  assert_shift_upper_R3: assert property (@(posedge dclk) disable iff (!rst_n)
    !mode |=> shadow_q[W-1:1] == $past(shadow_q[W-2:0]));

  assert_capture_y_R5: assert property (@(posedge dclk) disable iff (!rst_n)
    (mode && !sdi) |=> shadow_q == $past(y_in));

  assert_present_hold_R6: assert property (@(posedge dclk) disable iff (!rst_n)
    (mode && sdi) |=> (shadow_q == $past(shadow_q)) && d_oe);

  assert_drive_clear_R6: assert property (@(posedge dclk) disable iff (!rst_n)
    !(mode && sdi) |=> !d_oe);

endmodule

bind scan_pipe_reg scan_pipe_reg_chk #(.W(W)) u_chk (
  .rst_n    (rst_n),
  .dclk     (dclk),
  .pclk     (pclk),
  .mode     (mode),
  .sdi      (sdi),
  .d_in     (d_in),
  .y_in     (y_in),
  .y_out    (y_out),
  .d_oe     (d_oe),
  .shadow_q (shadow_q)
);

// File: tb/scan_pipe_reg_bench.sv
module scan_pipe_reg_bench;

  localparam int W = 8;
  localparam int KY = 0, KSDO = 1, KDOUT = 2, KDOE = 3, KYOE = 4;

  typedef struct {
    int          req;
    int          kind;
    logic [15:0] exp;
  } item_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, dclk = 1'b0, pclk = 1'b0, mode = 1'b0, sdi0 = 1'b0, oey_n = 1'b0;
  logic [W-1:0] d_drv0 = '0, d_drv1 = '0;

  logic sdo0, sdo1, d_oe0, d_oe1, y_oe0, y_oe1;
  logic [W-1:0] d_out0, d_out1, y_out0, y_out1, d_in0, d_in1, y_in0, y_in1;

  // Line resolution: driven value wins, released Y lines pull high.
  assign d_in0 = d_oe0 ? d_out0 : d_drv0;
  assign d_in1 = d_oe1 ? d_out1 : d_drv1;
  assign y_in0 = y_oe0 ? y_out0 : '1;
  assign y_in1 = y_oe1 ? y_out1 : '1;

  scan_pipe_reg #(.W(W)) u_scan_pipe_reg (
    .rst_n(rst_n), .dclk(dclk), .pclk(pclk), .mode(mode), .sdi(sdi0), .sdo(sdo0),
    .d_in(d_in0), .d_out(d_out0), .d_oe(d_oe0), .y_in(y_in0), .y_out(y_out0),
    .y_oe(y_oe0), .oey_n(oey_n));

  scan_pipe_reg #(.W(W)) u_scan_pipe_reg_tail (
    .rst_n(rst_n), .dclk(dclk), .pclk(pclk), .mode(mode), .sdi(sdo0), .sdo(sdo1),
    .d_in(d_in1), .d_out(d_out1), .d_oe(d_oe1), .y_in(y_in1), .y_out(y_out1),
    .y_oe(y_oe1), .oey_n(oey_n));

  int total = 0, bad = 0;
  bit done = 1'b0;
  item_t sb[$];

  // Reference model of the two-stage chain: tail stage is the upper byte.
  logic [15:0] ref_sh = '0, ref_pipe = '0;
  logic        ref_doe = 1'b0;

  task automatic push(int req, int kind, logic [15:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb.push_back(it);
  endtask

  // Wait until the monitor has consumed the queue.
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic step(bit dc, bit pc);
    logic [15:0] d_eff, y_eff, n_sh, n_pipe;
    logic        n_doe;
    d_eff  = ref_doe ? ref_sh : {d_drv1, d_drv0};
    y_eff  = oey_n ? 16'hFFFF : ref_pipe;
    n_sh   = ref_sh; n_pipe = ref_pipe; n_doe = ref_doe;
    if (dc) begin
      if (!mode)     n_sh = {ref_sh[14:0], sdi0};
      else if (!sdi0) n_sh = y_eff;
      n_doe = mode && sdi0;
    end
    if (pc) n_pipe = mode ? ref_sh : d_eff;
    #2;
    dclk = dc; pclk = pc;
    #5;
    dclk = 1'b0; pclk = 1'b0;
    #3;
    ref_sh = n_sh; ref_pipe = n_pipe; ref_doe = n_doe;
  endtask

  function automatic logic exp_sdo();
    return mode ? sdi0 : ref_sh[15];
  endfunction

  // Monitor: pops expected items and compares against the ports.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.kind)
        KY:      act = {y_out1, y_out0};
        KSDO:    act = {15'd0, sdo1};
        KDOUT:   act = {d_out1, d_out0};
        KDOE:    act = {14'd0, d_oe1, d_oe0};
        default: act = {14'd0, y_oe1, y_oe0};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL R%0d kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  // Watchdog.
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [15:0] WORD_A = 16'hB5C3;
  localparam logic [15:0] WORD_B = 16'h2E71;

  initial begin
    // R1: reset state
    #23;
    push(1, KY, 16'h0000); push(1, KDOE, 16'h0); push(1, KSDO, 16'h0);
    push(1, KDOUT, 16'h0000);
    settle();
    rst_n = 1'b1;
    settle();

    // R2: normal load from D
    mode = 1'b0; d_drv1 = 8'h5A; d_drv0 = 8'hA5;
    step(1'b0, 1'b1);
    push(2, KY, ref_pipe); push(8, KYOE, 16'h3);
    settle();

    // R3, R10: scan WORD_A in MSB first; one shift coincides with a D load.
    for (int i = 15; i >= 0; i--) begin
      sdi0 = WORD_A[i];
      if (i == 7) begin
        d_drv1 = 8'h3C; d_drv0 = 8'h96;
        step(1'b1, 1'b1);
        push(10, KY, 16'h3C96);
      end else begin
        step(1'b1, 1'b0);
      end
      push(3, KSDO, {15'd0, exp_sdo()});
      settle();
    end
    push(3, KDOUT, WORD_A);
    settle();

    // R7: bypass in mode 1
    mode = 1'b1; sdi0 = 1'b1; #2;
    push(7, KSDO, 16'h1); settle();
    sdi0 = 1'b0; #2;
    push(7, KSDO, 16'h0); settle();

    // R4: shadow into pipeline
    step(1'b0, 1'b1);
    push(4, KY, WORD_A); settle();

    // R6: present shadow on D, shadow held
    sdi0 = 1'b1;
    step(1'b1, 1'b0);
    push(6, KDOE, 16'h3); push(6, KDOUT, WORD_A); settle();
    step(1'b1, 1'b0);
    push(6, KDOUT, WORD_A); settle();

    // R5: capture Y (clears drive enable, R6)
    sdi0 = 1'b0;
    step(1'b1, 1'b0);
    push(6, KDOE, 16'h0); push(5, KDOUT, WORD_A); settle();

    // Load WORD_B into the pipeline from D
    mode = 1'b0; d_drv1 = WORD_B[15:8]; d_drv0 = WORD_B[7:0];
    step(1'b0, 1'b1);
    push(2, KY, WORD_B); settle();

    // R9: swap on coincident edges
    mode = 1'b1; sdi0 = 1'b0;
    step(1'b1, 1'b1);
    push(9, KY, WORD_A); push(9, KDOUT, WORD_B); settle();

    // Scan out and compare with WORD_B bit by bit
    mode = 1'b0; sdi0 = 1'b0; #2;
    for (int i = 15; i >= 0; i--) begin
      push(9, KSDO, {15'd0, WORD_B[i]});
      settle();
      step(1'b1, 1'b0);
    end

    // R8: Y released; R5 capture sees pulled-up lines
    oey_n = 1'b1; #2;
    push(8, KYOE, 16'h0); push(8, KY, WORD_A); settle();
    mode = 1'b1; sdi0 = 1'b0;
    step(1'b1, 1'b0);
    push(5, KDOUT, 16'hFFFF); settle();

    // R1: asynchronous reset clears everything again
    sdi0 = 1'b1;
    step(1'b1, 1'b0);
    rst_n = 1'b0; #2;
    ref_sh = '0; ref_pipe = '0; ref_doe = 1'b0;
    push(1, KDOE, 16'h0); push(1, KY, 16'h0000); push(1, KDOUT, 16'h0000);
    settle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule